// File: doc/BRIEF.md
# Dual Palette and Channel LUT Register Slave

This block is a register slave on a narrow display-control bus. It holds two colour palettes of 24-bit entries and one lookup RAM made of separate 8-bit red, green and blue tables. A bus master reaches a target with a device code and a register code. Writes go through an index register: the master first loads an index, then writes entry data to the location it points at. The palette index stays where it is after an entry write. The channel LUT index advances by one after each entry write, so a whole ramp can be streamed with one index load. One device code reaches both palettes at once, so they can be loaded with identical contents in a single pass.

A separate pixel-side port reads the palettes for overlay pixels. It forms an 8-bit overlay code from two nibbles of a frame word and returns the selected palette's entry one cycle later. A zero code is flagged as transparent. The pixel port does not depend on the bus, so display refresh continues while software rewrites the palettes.

Top module: `dpal_slave`

## Requirements
- R1: A write with device code 1 goes to both palettes. It loads the same index into both, or stores the same entry in both at their current index.
- R2: Device code 2 reaches palette A only and device code 3 reaches palette B only. A write to one of them leaves the other palette's index and entries unchanged.
- R3: On a palette, register code 0 loads the 16-bit index from write data bits 15:0. Register code 2 stores write data bits 31:8 at the location given by the low PAL_IDX_W bits of the index (default 10), and the index does not change.
- R4: A palette write with any register code other than 0 or 2 changes nothing. A write to a device code other than 1, 2, 3 or 7 also changes nothing.
- R5: On the channel LUT (device code 7), register code 0 loads the 8-bit LUT index from write data bits 7:0.
- R6: On the channel LUT, register code 1 stores red from data bits 15:8, green from bits 23:16 and blue from bits 31:24 at the current index. The index then increments by one, wrapping from 255 to 0.
- R7: A bus read returns its data on bus_rdata in the cycle after bus_rd is sampled. Palette register 0 returns {16'h0, index}. Palette register 2 returns {entry, 8'h00}. LUT register 0 returns the zero-extended index. LUT register 1 returns {blue, green, red, 8'h00}. A read with device code 1 returns palette A. Any other read returns 0.
- R8: A pixel request forms the overlay code {pix_word[19:16], pix_word[11:8]} and reads that entry from palette B when pix_bank is 1, otherwise from palette A. The result appears on pix_rgb one cycle later. A code of zero gives pix_clear = 1 and pix_rgb = 0.
- R9: A pixel read that meets a bus entry write to the same palette location in the same cycle returns the entry as it was before the write.
- R10: After synchronous reset, all indices are 0 and bus_rdata, pix_rgb and pix_clear are 0. A write takes effect at the first rising edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_dev | input | 4 | Device code |
| bus_reg | input | 3 | Register code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| pix_req | input | 1 | Pixel lookup request |
| pix_bank | input | 1 | Palette choice for the lookup (0 = A, 1 = B) |
| pix_word | input | 32 | Frame word holding the overlay nibbles |
| pix_rgb | output | 24 | Looked-up entry, one cycle after pix_req |
| pix_clear | output | 1 | Looked-up code was zero (transparent) |

## Verification
The hardest case to reach is a pixel lookup and a bus entry write that hit the same palette location in the same clock edge. The bench drives both strobes from one task in the same cycle, with the overlay nibbles set to the written index. It then checks that the old entry comes back, and that a second lookup afterwards returns the new entry. A second hard case is the LUT index wrap. The bench loads index 255 and writes one entry. It then reads the index back as 0 and the data back from location 255.

// File: rtl/dpal_pkg.sv
package dpal_pkg;

    localparam int unsigned BUS_DW   = 32;
    localparam int unsigned DEV_W    = 4;
    localparam int unsigned REG_W    = 3;
    localparam int unsigned PIDX_REG = 16;
    localparam int unsigned ENT_W    = 24;
    localparam int unsigned CH_W     = 8;
    localparam int unsigned CODE_W   = 8;

    localparam logic [DEV_W-1:0] DEV_PAL_BOTH = 4'd1;
    localparam logic [DEV_W-1:0] DEV_PAL_A    = 4'd2;
    localparam logic [DEV_W-1:0] DEV_PAL_B    = 4'd3;
    localparam logic [DEV_W-1:0] DEV_LUT      = 4'd7;

    localparam logic [REG_W-1:0] PREG_INDEX = 3'd0;
    localparam logic [REG_W-1:0] PREG_ENTRY = 3'd2;
    localparam logic [REG_W-1:0] LREG_INDEX = 3'd0;
    localparam logic [REG_W-1:0] LREG_ENTRY = 3'd1;

    typedef struct packed {
        logic pa_idx;
        logic pa_ent;
        logic pb_idx;
        logic pb_ent;
        logic lut_idx;
        logic lut_ent;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_PA_IDX,
        RS_PA_ENT,
        RS_PB_IDX,
        RS_PB_ENT,
        RS_LUT_IDX,
        RS_LUT_ENT
    } rd_src_t;

    function automatic logic [CODE_W-1:0] overlay_code(input logic [BUS_DW-1:0] word);
        return {word[19:16], word[11:8]};
    endfunction

endpackage

// File: rtl/dpal_decode.sv
module dpal_decode
    import dpal_pkg::*;
(
    input  logic             wr,
    input  logic             rd,
    input  logic [DEV_W-1:0] dev,
    input  logic [REG_W-1:0] rsel,
    output wr_strobe_t       wstb,
    output rd_src_t          rsrc
);

    logic hit_a, hit_b, hit_l;

    always_comb begin
        hit_a = (dev == DEV_PAL_BOTH) || (dev == DEV_PAL_A);
        hit_b = (dev == DEV_PAL_BOTH) || (dev == DEV_PAL_B);
        hit_l = (dev == DEV_LUT);

        wstb         = '0;
        wstb.pa_idx  = wr && hit_a && (rsel == PREG_INDEX);
        wstb.pa_ent  = wr && hit_a && (rsel == PREG_ENTRY);
        wstb.pb_idx  = wr && hit_b && (rsel == PREG_INDEX);
        wstb.pb_ent  = wr && hit_b && (rsel == PREG_ENTRY);
        wstb.lut_idx = wr && hit_l && (rsel == LREG_INDEX);
        wstb.lut_ent = wr && hit_l && (rsel == LREG_ENTRY);

        rsrc = RS_NONE;
        if (rd) begin
            if (hit_a) begin
                if (rsel == PREG_INDEX)      rsrc = RS_PA_IDX;
                else if (rsel == PREG_ENTRY) rsrc = RS_PA_ENT;
            end else if (hit_b) begin
                if (rsel == PREG_INDEX)      rsrc = RS_PB_IDX;
                else if (rsel == PREG_ENTRY) rsrc = RS_PB_ENT;
            end else if (hit_l) begin
                if (rsel == LREG_INDEX)      rsrc = RS_LUT_IDX;
                else if (rsel == LREG_ENTRY) rsrc = RS_LUT_ENT;
            end
        end
    end

endmodule

// File: rtl/dpal_bank.sv
module dpal_bank
    import dpal_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_we,
    input  logic                ent_we,
    input  logic [BUS_DW-1:0]   wdata,
    output logic [PIDX_REG-1:0] idx_q,
    input  logic                bus_re,
    output logic [ENT_W-1:0]    bus_ent,
    input  logic                pix_re,
    input  logic [CODE_W-1:0]   pix_code,
    output logic [ENT_W-1:0]    pix_ent
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] waddr;
    logic [IDX_W-1:0] paddr;

    assign waddr = idx_q[IDX_W-1:0];
    assign paddr = IDX_W'(pix_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata[PIDX_REG-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (ent_we) begin
            mem[waddr] <= wdata[BUS_DW-1:BUS_DW-ENT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ent <= '0;
            pix_ent <= '0;
        end else begin
            if (bus_re) bus_ent <= mem[waddr];
            if (pix_re) pix_ent <= mem[paddr];
        end
    end

    AST_PAL_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ent_we && !idx_we) |=> (idx_q == $past(idx_q)))  // R3
        else $error("palette index moved on entry write");

endmodule

// File: rtl/dpal_lut.sv
module dpal_lut
    import dpal_pkg::*;
#(
    parameter int unsigned LIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_we,
    input  logic              ent_we,
    input  logic [BUS_DW-1:0] wdata,
    output logic [LIDX_W-1:0] idx_q,
    input  logic              bus_re,
    output logic [3*CH_W-1:0] bus_bgr
);

    localparam int unsigned DEPTH = 1 << LIDX_W;
    localparam int unsigned NCH   = 3;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CH_W-1:0] tbl [DEPTH];
        logic [CH_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (ent_we) begin
                tbl[idx_q] <= wdata[CH_W*(c+1) +: CH_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
            end else if (bus_re) begin
                rd_q <= tbl[idx_q];
            end
        end

        assign bus_bgr[CH_W*c +: CH_W] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata[LIDX_W-1:0];
        end else if (ent_we) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    AST_LUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ent_we && !idx_we) |=> (idx_q == LIDX_W'($past(idx_q) + 1'b1)))  // R6
        else $error("LUT index did not advance");

endmodule

// File: rtl/dpal_slave.sv
module dpal_slave
    import dpal_pkg::*;
#(
    parameter int unsigned PAL_IDX_W = 10,
    parameter int unsigned LUT_IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_dev,
    input  logic [2:0]        bus_reg,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pix_req,
    input  logic              pix_bank,
    input  logic [31:0]       pix_word,
    output logic [23:0]       pix_rgb,
    output logic              pix_clear
);

    wr_strobe_t           wstb;
    rd_src_t              rsrc, rsrc_q;
    logic [PIDX_REG-1:0]  idx_a, idx_b;
    logic [LUT_IDX_W-1:0] idx_l;
    logic [ENT_W-1:0]     ent_a, ent_b, pix_a, pix_b;
    logic [3*CH_W-1:0]    lut_bgr;
    logic [PIDX_REG-1:0]  idx_snap_q;
    logic [CODE_W-1:0]    code;
    logic                 bank_q, clear_q;

    assign code = overlay_code(pix_word);

    dpal_decode u_dec (
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dev  (bus_dev),
        .rsel (bus_reg),
        .wstb (wstb),
        .rsrc (rsrc)
    );

    dpal_bank #(.IDX_W(PAL_IDX_W)) u_bank_a (
        .clk      (clk),
        .rst      (rst),
        .idx_we   (wstb.pa_idx),
        .ent_we   (wstb.pa_ent),
        .wdata    (bus_wdata),
        .idx_q    (idx_a),
        .bus_re   (rsrc == RS_PA_ENT),
        .bus_ent  (ent_a),
        .pix_re   (pix_req && !pix_bank),
        .pix_code (code),
        .pix_ent  (pix_a)
    );

    dpal_bank #(.IDX_W(PAL_IDX_W)) u_bank_b (
        .clk      (clk),
        .rst      (rst),
        .idx_we   (wstb.pb_idx),
        .ent_we   (wstb.pb_ent),
        .wdata    (bus_wdata),
        .idx_q    (idx_b),
        .bus_re   (rsrc == RS_PB_ENT),
        .bus_ent  (ent_b),
        .pix_re   (pix_req && pix_bank),
        .pix_code (code),
        .pix_ent  (pix_b)
    );

    dpal_lut #(.LIDX_W(LUT_IDX_W)) u_lut (
        .clk     (clk),
        .rst     (rst),
        .idx_we  (wstb.lut_idx),
        .ent_we  (wstb.lut_ent),
        .wdata   (bus_wdata),
        .idx_q   (idx_l),
        .bus_re  (rsrc == RS_LUT_ENT),
        .bus_bgr (lut_bgr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsrc_q     <= RS_NONE;
            idx_snap_q <= '0;
            bank_q     <= 1'b0;
            clear_q    <= 1'b0;
        end else begin
            rsrc_q <= rsrc;
            case (rsrc)
                RS_PA_IDX:  idx_snap_q <= idx_a;
                RS_PB_IDX:  idx_snap_q <= idx_b;
                RS_LUT_IDX: idx_snap_q <= PIDX_REG'(idx_l);
                default:    idx_snap_q <= idx_snap_q;
            endcase
            if (pix_req) begin
                bank_q  <= pix_bank;
                clear_q <= (code == '0);
            end
        end
    end

    always_comb begin
        case (rsrc_q)
            RS_PA_IDX, RS_PB_IDX, RS_LUT_IDX: bus_rdata = {16'h0, idx_snap_q};
            RS_PA_ENT:  bus_rdata = {ent_a, 8'h00};
            RS_PB_ENT:  bus_rdata = {ent_b, 8'h00};
            RS_LUT_ENT: bus_rdata = {lut_bgr, 8'h00};
            default:    bus_rdata = '0;
        endcase
    end

    assign pix_clear = clear_q;
    assign pix_rgb   = clear_q ? '0 : (bank_q ? pix_b : pix_a);

    AST_BCAST_IDX: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_dev == DEV_PAL_BOTH && bus_reg == PREG_INDEX) |=> (idx_a == idx_b))  // R1
        else $error("broadcast index mismatch");

    AST_PAL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_dev == DEV_PAL_A || bus_dev == DEV_PAL_B || bus_dev == DEV_PAL_BOTH)
         && bus_reg != PREG_INDEX && bus_reg != PREG_ENTRY)
        |=> ($stable(idx_a) && $stable(idx_b)))  // R4
        else $error("ignored palette register changed an index");

    AST_PIX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pix_req && overlay_code(pix_word) == '0) |=> (pix_clear && pix_rgb == '0))  // R8
        else $error("zero overlay code not transparent");

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> (bus_rdata == '0))  // R7
        else $error("read data without a read");

endmodule

// File: tb/dpal_slave_tb.sv
module dpal_slave_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_dev;
    logic [2:0]  bus_reg;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pix_req, pix_bank;
    logic [31:0] pix_word;
    logic [23:0] pix_rgb;
    logic        pix_clear;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dpal_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_dev   (bus_dev),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_req   (pix_req),
        .pix_bank  (pix_bank),
        .pix_word  (pix_word),
        .pix_rgb   (pix_rgb),
        .pix_clear (pix_clear)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] dev, input logic [2:0] rg, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_dev = dev; bus_reg = rg; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] dev, input logic [2:0] rg, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_dev = dev; bus_reg = rg;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pix(input logic bank, input logic [7:0] code,
                       output logic [23:0] rgb, output logic clr);
        @(negedge clk);
        pix_req = 1'b1; pix_bank = bank;
        pix_word = {12'hABC, code[7:4], 4'h9, code[3:0], 8'h77};
        @(negedge clk);
        rgb = pix_rgb; clr = pix_clear;
        pix_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk("R10 rdata", bus_rdata, 32'h0);
        chk("R10 pix_rgb", {8'h0, pix_rgb}, 32'h0);
        chk("R10 pix_clear", {31'h0, pix_clear}, 32'h0);
        rd(4'd2, 3'd0, d); chk("R10 idx A", d, 32'h0);
        rd(4'd3, 3'd0, d); chk("R10 idx B", d, 32'h0);
        rd(4'd7, 3'd0, d); chk("R10 idx LUT", d, 32'h0);
    endtask

    task automatic t_individual();
        logic [31:0] d;
        wr(4'd2, 3'd0, 32'h0000_0005);
        wr(4'd2, 3'd2, 32'h1122_33FF);
        wr(4'd3, 3'd0, 32'h0000_0005);
        wr(4'd3, 3'd2, 32'h4455_66EE);
        rd(4'd2, 3'd2, d); chk("R2 entry A", d, 32'h1122_3300);
        rd(4'd3, 3'd2, d); chk("R2 entry B", d, 32'h4455_6600);
        rd(4'd2, 3'd0, d); chk("R3 index held after entry write", d, 32'h5);
        wr(4'd2, 3'd0, 32'hFFFF_ABCD);
        rd(4'd2, 3'd0, d); chk("R3 index 16 bit", d, 32'h0000_ABCD);
        rd(4'd3, 3'd0, d); chk("R2 idx B untouched", d, 32'h5);
        wr(4'd2, 3'd2, 32'hCAFE_0100);
        wr(4'd2, 3'd0, 32'h0000_03CD);
        rd(4'd2, 3'd2, d); chk("R3 low index bits address", d, 32'hCAFE_0100);
    endtask

    task automatic t_broadcast();
        logic [31:0] d;
        wr(4'd1, 3'd0, 32'h0000_0021);
        wr(4'd1, 3'd2, 32'hA1B2_C3D4);
        rd(4'd2, 3'd0, d); chk("R1 idx A", d, 32'h21);
        rd(4'd3, 3'd0, d); chk("R1 idx B", d, 32'h21);
        rd(4'd2, 3'd2, d); chk("R1 entry A", d, 32'hA1B2_C300);
        rd(4'd3, 3'd2, d); chk("R1 entry B", d, 32'hA1B2_C300);
        rd(4'd1, 3'd2, d); chk("R7 broadcast read", d, 32'hA1B2_C300);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        wr(4'd2, 3'd1, 32'h0000_0099);
        wr(4'd2, 3'd3, 32'hDEAD_BEEF);
        wr(4'd0, 3'd0, 32'h0000_0077);
        wr(4'd5, 3'd2, 32'h0BAD_F00D);
        rd(4'd2, 3'd0, d); chk("R4 idx A kept", d, 32'h21);
        rd(4'd2, 3'd2, d); chk("R4 entry A kept", d, 32'hA1B2_C300);
        rd(4'd3, 3'd2, d); chk("R4 entry B kept", d, 32'hA1B2_C300);
        rd(4'd2, 3'd5, d); chk("R7 bad reg read", d, 32'h0);
        rd(4'd0, 3'd0, d); chk("R7 bad dev read", d, 32'h0);
    endtask

    task automatic t_lut();
        logic [31:0] d;
        wr(4'd7, 3'd0, 32'hFFFF_FF10);
        rd(4'd7, 3'd0, d); chk("R5 lut index", d, 32'h10);
        wr(4'd7, 3'd1, 32'h3322_1100);
        wr(4'd7, 3'd1, 32'h6655_4400);
        rd(4'd7, 3'd0, d); chk("R6 lut advanced", d, 32'h12);
        wr(4'd7, 3'd0, 32'h0000_0010);
        rd(4'd7, 3'd1, d); chk("R6 lut entry 0x10", d, 32'h3322_1100);
        wr(4'd7, 3'd0, 32'h0000_0011);
        rd(4'd7, 3'd1, d); chk("R6 lut entry 0x11", d, 32'h6655_4400);
        wr(4'd7, 3'd0, 32'h0000_00FF);
        wr(4'd7, 3'd1, 32'hC0B0_A0FF);
        rd(4'd7, 3'd0, d); chk("R6 lut wrap", d, 32'h0);
        wr(4'd7, 3'd0, 32'h0000_00FF);
        rd(4'd7, 3'd1, d); chk("R6 lut entry 0xFF", d, 32'hC0B0_A000);
    endtask

    task automatic t_pixel();
        logic [23:0] rgb;
        logic        clr;
        wr(4'd3, 3'd0, 32'h0000_0025);
        wr(4'd3, 3'd2, 32'h0F1E_2D00);
        wr(4'd2, 3'd0, 32'h0000_0025);
        wr(4'd2, 3'd2, 32'h7788_9900);
        pix(1'b1, 8'h25, rgb, clr);
        chk("R8 bank B lookup", {8'h0, rgb}, 32'h000F_1E2D);
        chk("R8 not clear", {31'h0, clr}, 32'h0);
        pix(1'b0, 8'h25, rgb, clr);
        chk("R8 bank A lookup", {8'h0, rgb}, 32'h0077_8899);
        pix(1'b0, 8'h00, rgb, clr);
        chk("R8 transparent flag", {31'h0, clr}, 32'h1);
        chk("R8 transparent rgb", {8'h0, rgb}, 32'h0);
    endtask

    task automatic t_collide();
        logic [23:0] rgb;
        @(negedge clk);
        bus_wr = 1'b1; bus_dev = 4'd2; bus_reg = 3'd2; bus_wdata = 32'h5566_7700;
        pix_req = 1'b1; pix_bank = 1'b0;
        pix_word = {12'h000, 4'h2, 4'h0, 4'h5, 8'h00};
        @(negedge clk);
        bus_wr = 1'b0; pix_req = 1'b0;
        chk("R9 old data on collision", {8'h0, pix_rgb}, 32'h0077_8899);
        pix(1'b0, 8'h25, rgb, rgb[0]);
        chk("R9 new data after", {8'h0, rgb[23:1], 1'b0}, 32'h0055_6676);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_dev = 0; bus_reg = 0;
        bus_wdata = 0; pix_req = 0; pix_bank = 0; pix_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_individual();
        t_broadcast();
        t_ignore();
        t_lut();
        t_pixel();
        t_collide();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule